// File: doc/BRIEF.md
# ATAPI Packet Command Register State Machine

This block is the device side of the register interface for the ATAPI PACKET command path. A host does byte-wide reads and writes through a small register window: error/feature, interrupt reason, byte count low and high, device, status/command and an alternate status/device control address. A separate 16-bit data port takes the 12-byte command packet and returns the words of a PIO data-in phase.

The block does not interpret the packet. When the busy period after the packet ends, it samples a response length and a failure flag on its inputs. These are normally driven by a model or by other logic. It then walks the status byte, the interrupt-reason code and the byte-count registers through the data-in, completion or error phase, with a fixed register image in each phase. Response words are loaded into an internal buffer through a write port. An interrupt line goes high at each phase that needs host attention. Reading the status register clears it, and a bit in device control masks it.

Top module: `atapi_pkt_fsm`

## Requirements
- R1: After reset, status and alternate status read 0x50, error reads 0x00, interrupt reason reads 0x00 and `intrq` is low.
- R2: The selects are mapped as follows: `tf_sel` 1 is interrupt reason, 2 is byte count low, 3 is byte count high and 4 is device. Each of these reads back what was last written. A write to select 0 (feature) is accepted, but reads at select 0 return the error register.
- R3: While the busy bit (status bit 7) is set, every register write is ignored, including writes to device control.
- R4: Writing 0xA0 to select 5 gives status 0x58 and interrupt reason 0x01. The byte-count registers keep their values and `intrq` stays low until the packet is taken. Any other command code leaves the state unchanged.
- R5: The sixth data-port write in the packet phase sets status to 0xD0. The busy state lasts exactly `BUSY_CYCLES` clock edges, and `intrq` rises at the edge that ends it.
- R6: If the response length is non-zero and the failure flag is clear, the next phase reads status 0x58 and interrupt reason 0x02. Byte count low and high then hold the response length, and `intrq` is raised.
- R7: In the data-in phase, each data-port read returns the next buffer word, starting at address 0.
- R8: After ceil(length/2) data reads, status reads 0x50, interrupt reason reads 0x03, error reads 0x00 and `intrq` is raised. A zero length goes straight to this state at the end of busy, with both byte-count registers cleared.
- R9: If the failure flag is set when busy ends, status reads 0x51, error reads 0x60, interrupt reason reads 0x03 and `intrq` is raised.
- R10: A read at select 5 (status) clears `intrq`. A read at select 6 (alternate status) leaves it unchanged.
- R11: A read at select 6 returns the same byte as status.
- R12: A write at select 6 stores device control. Bit 1 set holds `intrq` low without discarding the pending request, and clearing the bit lets the request through again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tf_sel | input | 3 | Register select |
| tf_wr | input | 1 | Register write strobe |
| tf_rd | input | 1 | Register read strobe (status read side effect) |
| tf_wdata | input | 8 | Register write data |
| tf_rdata | output | 8 | Register read data for `tf_sel` |
| dp_wr | input | 1 | Data-port write strobe (packet words) |
| dp_wdata | input | 16 | Data-port write word |
| dp_rd | input | 1 | Data-port read strobe |
| dp_rdata | output | 16 | Current response word in data-in, else 0 |
| rb_wr | input | 1 | Response buffer write strobe |
| rb_addr | input | AW | Response buffer word address |
| rb_wdata | input | 16 | Response buffer word |
| resp_len | input | 16 | Response length in bytes, sampled when busy ends |
| resp_fail | input | 1 | Command failure flag, sampled when busy ends |
| intrq | output | 1 | Interrupt request to the host |

## Verification
The in-line assertions check several rules on every cycle. The interrupt stays quiet through packet acceptance and busy, and the sixth packet word always leads to busy. Busy holds until its counter ends, and register state is frozen during busy. A status read drops the interrupt, an alternate read keeps it, and the final data read always lands in completion with the interrupt pending. The exact register images in each phase, the word order out of the buffer, the length of the busy window, the zero-length and failure paths, and the masking through device control are shown only by the bench's scenarios, which compare every read against an expected queue.

// File: rtl/atapi_pkt_fsm.sv
module atapi_pkt_fsm #(
  parameter int BUSY_CYCLES = 4,
  parameter int RB_DEPTH    = 16,
  localparam int AW = $clog2(RB_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    tf_sel,
  input  logic          tf_wr,
  input  logic          tf_rd,
  input  logic [7:0]    tf_wdata,
  output logic [7:0]    tf_rdata,
  input  logic          dp_wr,
  input  logic [15:0]   dp_wdata,
  input  logic          dp_rd,
  output logic [15:0]   dp_rdata,
  input  logic          rb_wr,
  input  logic [AW-1:0] rb_addr,
  input  logic [15:0]   rb_wdata,
  input  logic [15:0]   resp_len,
  input  logic          resp_fail,
  output logic          intrq
);

  localparam int BW = $clog2(BUSY_CYCLES + 1);

  localparam logic [2:0] SEL_ERR  = 3'd0;
  localparam logic [2:0] SEL_RSN  = 3'd1;
  localparam logic [2:0] SEL_BCL  = 3'd2;
  localparam logic [2:0] SEL_BCH  = 3'd3;
  localparam logic [2:0] SEL_DEV  = 3'd4;
  localparam logic [2:0] SEL_STAT = 3'd5;
  localparam logic [2:0] SEL_ALT  = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_PKT, S_BUSY, S_DATA, S_DONE, S_FAIL} st_e;

  st_e           st;
  logic [7:0]    rsn, bcl, bch, dev, err, status;
  logic          nien, irq;
  logic [2:0]    wcnt;
  logic [BW-1:0] bcnt;
  logic [15:0]   left;
  logic [AW-1:0] ridx;
  logic [15:0]   mem [RB_DEPTH];

  logic busy, wr_ok, busy_end, last_rd, unused_pkt;

  assign busy     = (st == S_BUSY);
  assign wr_ok    = tf_wr && !busy;
  assign busy_end = busy && (bcnt == '0);
  assign last_rd  = (st == S_DATA) && dp_rd && (left <= 16'd2);
  assign unused_pkt = ^dp_wdata;

  always_comb begin
    case (st)
      S_PKT:   status = 8'h58;
      S_BUSY:  status = 8'hD0;
      S_DATA:  status = 8'h58;
      S_FAIL:  status = 8'h51;
      default: status = 8'h50;
    endcase
  end

  always_comb begin
    case (tf_sel)
      SEL_ERR:           tf_rdata = err;
      SEL_RSN:           tf_rdata = rsn;
      SEL_BCL:           tf_rdata = bcl;
      SEL_BCH:           tf_rdata = bch;
      SEL_DEV:           tf_rdata = dev;
      SEL_STAT, SEL_ALT: tf_rdata = status;
      default:           tf_rdata = 8'h00;
    endcase
  end

  assign dp_rdata = (st == S_DATA) ? mem[ridx] : 16'h0000;
  assign intrq    = irq && !nien;

  always_ff @(posedge clk) begin
    if (rb_wr) mem[rb_addr] <= rb_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      rsn  <= '0;
      bcl  <= '0;
      bch  <= '0;
      dev  <= '0;
      err  <= '0;
      nien <= 1'b0;
      irq  <= 1'b0;
      wcnt <= '0;
      bcnt <= '0;
      left <= '0;
      ridx <= '0;
    end else begin
      if (tf_rd && tf_sel == SEL_STAT) irq <= 1'b0;

      case (st)
        S_PKT: if (dp_wr) begin
          if (wcnt == 3'd5) begin
            st   <= S_BUSY;
            bcnt <= BW'(BUSY_CYCLES - 1);
          end else begin
            wcnt <= wcnt + 3'd1;
          end
        end
        S_BUSY: begin
          if (bcnt != '0) begin
            bcnt <= bcnt - 1'b1;
          end else begin
            irq <= 1'b1;
            if (resp_fail) begin
              st  <= S_FAIL;
              err <= 8'h60;
              rsn <= 8'h03;
            end else if (resp_len == 16'd0) begin
              st  <= S_DONE;
              err <= 8'h00;
              rsn <= 8'h03;
              bcl <= 8'h00;
              bch <= 8'h00;
            end else begin
              st   <= S_DATA;
              rsn  <= 8'h02;
              bcl  <= resp_len[7:0];
              bch  <= resp_len[15:8];
              left <= resp_len;
              ridx <= '0;
            end
          end
        end
        S_DATA: if (dp_rd) begin
          ridx <= ridx + 1'b1;
          if (left <= 16'd2) begin
            st   <= S_DONE;
            rsn  <= 8'h03;
            err  <= 8'h00;
            irq  <= 1'b1;
            left <= '0;
          end else begin
            left <= left - 16'd2;
          end
        end
        default: ;
      endcase

      if (wr_ok) begin
        case (tf_sel)
          SEL_RSN: rsn  <= tf_wdata;
          SEL_BCL: bcl  <= tf_wdata;
          SEL_BCH: bch  <= tf_wdata;
          SEL_DEV: dev  <= tf_wdata;
          SEL_ALT: nien <= tf_wdata[1];
          SEL_STAT: if (tf_wdata == 8'hA0) begin
            st   <= S_PKT;
            rsn  <= 8'h01;
            err  <= 8'h00;
            irq  <= 1'b0;
            wcnt <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  a_r4_quiet_until_packet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PKT || st == S_BUSY) |-> !irq);

  a_r5_sixth_word_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PKT && dp_wr && wcnt == 3'd5 && !(wr_ok && tf_sel == SEL_STAT)) |=> (st == S_BUSY));

  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt != '0) |=> busy);

  a_r3_busy_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bcnt != '0 && tf_wr) |=> $stable({rsn, bcl, bch, dev, nien}));

  a_r10_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_rd && tf_sel == SEL_STAT && !busy_end && !last_rd) |=> !irq);

  a_r10_alt_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && tf_rd && tf_sel == SEL_ALT && !tf_wr) |=> irq);

  a_r8_last_read_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (last_rd && !tf_wr) |=> (st == S_DONE && irq));

endmodule

// File: tb/test_atapi_pkt_fsm.sv
`timescale 1ns/1ps
module test_atapi_pkt_fsm;
  localparam int BC = 6;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] tf_sel = '0;
  logic tf_wr = 1'b0, tf_rd = 1'b0;
  logic [7:0] tf_wdata = '0;
  logic [7:0] tf_rdata;
  logic dp_wr = 1'b0, dp_rd = 1'b0;
  logic [15:0] dp_wdata = '0;
  logic [15:0] dp_rdata;
  logic rb_wr = 1'b0;
  logic [AW-1:0] rb_addr = '0;
  logic [15:0] rb_wdata = '0;
  logic [15:0] resp_len = '0;
  logic resp_fail = 1'b0;
  logic intrq;

  always #2.5 clk = ~clk;

  atapi_pkt_fsm #(.BUSY_CYCLES(BC), .RB_DEPTH(DEPTH)) i_atapi_pkt_fsm (
    .clk(clk), .rst_n(rst_n), .tf_sel(tf_sel), .tf_wr(tf_wr), .tf_rd(tf_rd),
    .tf_wdata(tf_wdata), .tf_rdata(tf_rdata), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
    .dp_rd(dp_rd), .dp_rdata(dp_rdata), .rb_wr(rb_wr), .rb_addr(rb_addr),
    .rb_wdata(rb_wdata), .resp_len(resp_len), .resp_fail(resp_fail), .intrq(intrq));

  typedef struct { bit is_data; logic [15:0] exp; string tag; } item_t;
  item_t exp_q[$];
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always @(negedge clk) begin
    if (tf_rd || dp_rd) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL monitor: read with no expected item, actual %h expected none", tf_rdata);
      end else begin
        item_t it;
        logic [15:0] act;
        it = exp_q.pop_front();
        act = it.is_data ? dp_rdata : {8'h00, tf_rdata};
        if (act !== it.exp) begin
          n_err++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic tf_write(input logic [2:0] s, input logic [7:0] v);
    tf_sel = s; tf_wdata = v; tf_wr = 1'b1;
    @(posedge clk); #1; tf_wr = 1'b0;
  endtask

  task automatic tf_check(input logic [2:0] s, input logic [7:0] v, input string tag);
    exp_q.push_back('{1'b0, {8'h00, v}, tag});
    tf_sel = s; tf_rd = 1'b1;
    @(posedge clk); #1; tf_rd = 1'b0;
  endtask

  task automatic dp_write(input logic [15:0] w);
    dp_wdata = w; dp_wr = 1'b1;
    @(posedge clk); #1; dp_wr = 1'b0;
  endtask

  task automatic dp_check(input logic [15:0] w, input string tag);
    exp_q.push_back('{1'b1, w, tag});
    dp_rd = 1'b1;
    @(posedge clk); #1; dp_rd = 1'b0;
  endtask

  task automatic irq_check(input logic e, input string tag);
    n_chk++;
    if (intrq !== e) begin
      n_err++;
      $display("FAIL %s: intrq actual %b expected %b", tag, intrq, e);
    end
  endtask

  task automatic wait_irq(input int exp_n, input string tag);
    int n = 0;
    while (!intrq && n < 4 * BC + 8) begin
      @(posedge clk); #1; n++;
    end
    n_chk++;
    if (n != exp_n) begin
      n_err++;
      $display("FAIL %s: edges to intrq actual %0d expected %0d", tag, n, exp_n);
    end
  endtask

  task automatic send_packet();
    tf_write(3'd0, 8'h00);
    tf_write(3'd1, 8'h00);
    tf_write(3'd2, 8'h08);
    tf_write(3'd3, 8'h00);
    tf_write(3'd4, 8'h00);
    tf_write(3'd5, 8'hA0);
    for (int k = 0; k < 6; k++) dp_write(16'h1200 + 16'(k));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      rb_addr = AW'(i); rb_wdata = 16'hA000 + 16'(i) * 16'h0111; rb_wr = 1'b1;
      @(posedge clk); #1; rb_wr = 1'b0;
    end

    // R1 reset image
    tf_check(3'd5, 8'h50, "R1 status");
    tf_check(3'd6, 8'h50, "R1 altstatus");
    tf_check(3'd0, 8'h00, "R1 error");
    tf_check(3'd1, 8'h00, "R1 reason");
    irq_check(1'b0, "R1 intrq");

    // R2 register map
    tf_write(3'd1, 8'h5A);
    tf_write(3'd2, 8'h3C);
    tf_write(3'd3, 8'hC3);
    tf_write(3'd4, 8'hA5);
    tf_write(3'd0, 8'h77);
    tf_check(3'd1, 8'h5A, "R2 reason readback");
    tf_check(3'd2, 8'h3C, "R2 bcl readback");
    tf_check(3'd3, 8'hC3, "R2 bch readback");
    tf_check(3'd4, 8'hA5, "R2 device readback");
    tf_check(3'd0, 8'h00, "R2 feature not read back");

    // R4 other command code ignored
    tf_write(3'd5, 8'hEC);
    tf_check(3'd5, 8'h50, "R4 non-packet code ignored");

    // R4 packet accept image
    resp_len = 16'd7; resp_fail = 1'b0;
    tf_write(3'd1, 8'h00);
    tf_write(3'd2, 8'h08);
    tf_write(3'd3, 8'h00);
    tf_write(3'd4, 8'h00);
    tf_write(3'd5, 8'hA0);
    tf_check(3'd6, 8'h58, "R4 accept status");
    tf_check(3'd1, 8'h01, "R4 accept reason");
    tf_check(3'd2, 8'h08, "R4 bcl kept");
    tf_check(3'd3, 8'h00, "R4 bch kept");
    irq_check(1'b0, "R4 intrq low");
    for (int k = 0; k < 6; k++) dp_write(16'h4A00 + 16'(k));
    // R3 write during busy ignored; R5 busy image and length
    tf_write(3'd4, 8'h10);
    tf_check(3'd6, 8'hD0, "R5 busy status");
    wait_irq(BC - 2, "R5 busy length");

    // R6 data-in image, R10 read side effects, R11 alt equals status
    tf_check(3'd6, 8'h58, "R11 alt in data-in");
    irq_check(1'b1, "R10 alt read keeps intrq");
    tf_check(3'd1, 8'h02, "R6 reason");
    tf_check(3'd2, 8'h07, "R6 bcl length");
    tf_check(3'd3, 8'h00, "R6 bch length");
    tf_check(3'd4, 8'h00, "R3 device write in busy ignored");
    tf_check(3'd5, 8'h58, "R6 status");
    irq_check(1'b0, "R10 status read clears intrq");

    // R7 word order
    for (int k = 0; k < 4; k++) begin
      irq_check(1'b0, "R7 no intrq mid transfer");
      dp_check(16'hA000 + 16'(k) * 16'h0111, "R7 data word");
    end

    // R8 completion, R12 mask
    irq_check(1'b1, "R8 completion intrq");
    tf_write(3'd6, 8'h02);
    irq_check(1'b0, "R12 masked");
    tf_write(3'd6, 8'h00);
    irq_check(1'b1, "R12 unmasked pending kept");
    tf_check(3'd1, 8'h03, "R8 reason");
    tf_check(3'd0, 8'h00, "R8 error");
    tf_check(3'd5, 8'h50, "R8 status");
    irq_check(1'b0, "R10 cleared after completion");

    // R9 failure path; R3 devctl write during busy ignored
    resp_fail = 1'b1;
    send_packet();
    tf_write(3'd6, 8'h02);
    wait_irq(BC - 1, "R9 busy length");
    irq_check(1'b1, "R3 devctl write in busy ignored");
    tf_check(3'd6, 8'h51, "R9 alt status");
    tf_check(3'd0, 8'h60, "R9 error");
    tf_check(3'd1, 8'h03, "R9 reason");
    tf_check(3'd5, 8'h51, "R9 status");

    // R8 zero length goes straight to completion
    resp_fail = 1'b0; resp_len = 16'd0;
    send_packet();
    wait_irq(BC, "R8 zero length busy");
    tf_check(3'd5, 8'h50, "R8 zero length status");
    tf_check(3'd1, 8'h03, "R8 zero length reason");
    tf_check(3'd2, 8'h00, "R8 zero length bcl");
    tf_check(3'd3, 8'h00, "R8 zero length bch");

    @(posedge clk); #1;
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule